// File: doc/BRIEF.md
# Three-Stage Pipelined Register-Add Core

This block is a small in-order 32-bit core. It runs one kind of instruction: an add that takes two registers and writes a third. The pipeline has three stages. The first stage fetches a word from a 64-word internal instruction store. The second stage decodes the word and reads both source registers from a 32-entry register file. The third stage forms the sum and writes it back in the same cycle. While steady, three instructions are in flight and one retires per cycle.

An add in decode may read a register that the add in the last stage is writing in that same cycle. A build-time parameter chooses how this is handled. Forwarding mode routes the last-stage sum straight into the decode operand. Stall mode freezes fetch and decode for one cycle and sends an empty slot down the pipe. Every retired add shows its destination index and value on an observation port.

The instruction store and the register file each have a load port. These ports set up a program and its starting operands.

Top module: `pipe3_add_core`

## Requirements
- R1: An instruction word is an add only when bits [31:30] are 2'b10, bits [24:19] are 6'b000000 and bit [13] is 0. Its destination is bits [29:25], its first source is bits [18:14] and its second source is bits [4:0]. It writes rs1+rs2 modulo 2^32 to rd, and no carry is kept.
- R2: Any other word retires nothing. It changes no register and raises no write-back pulse.
- R3: Word k, fetched at the k+1-th rising edge after reset release, shows on the write-back port in the cycle after edge k+2. Independent adds retire on consecutive cycles.
- R4: In forwarding mode, an add that reads the destination of the add directly ahead of it gets the new sum, with no lost cycle.
- R5: In stall mode, that same dependency (through either source) holds fetch and decode for exactly one cycle. The dependent add then reads the new value.
- R6: With r2=2, r3=3 and r6=6, the sequence r1=r2+r3, r4=r1+r3, r5=r6+r3 retires r1=5, r4=8 and r5=9 in both modes.
- R7: The program counter starts at 0 and grows by 4 each cycle. It keeps its value in a stalled cycle.
- R8: A write-back pulse occurs only for a retired add. An inserted bubble raises none.
- R9: While reset is asserted, the program counter and the write-back pulse are 0. After reset every register reads 0.
- R10: A dependency two instructions apart reads the value already written, with no stall in either mode.
- R11: The instruction store holds 64 words, addressed by PC bits [7:2]. Fetch wraps to word 0 after word 63.
- R12: The register load port writes one register per cycle. A write from the pipeline to the same register in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_we | input | 1 | Instruction store write strobe |
| imem_waddr | input | 6 | Instruction store word address |
| imem_wdata | input | 32 | Instruction word to store |
| rf_pre_we | input | 1 | Register load strobe |
| rf_pre_idx | input | 5 | Register to load |
| rf_pre_data | input | 32 | Value to load |
| pc_o | output | 32 | Current fetch address |
| wb_valid | output | 1 | An add retires this cycle |
| wb_rd | output | 5 | Destination of the retiring add |
| wb_data | output | 32 | Value written by the retiring add |

## Verification
Two actions can fall in the same cycle: the last stage writes a register, and decode reads that same register. The bench provokes this by placing dependent adds back to back, through the first source in one case and the second source in another, and also in a chain. It judges the result in two ways: the retired value must equal the sum a correct in-order machine would give, and the retire cycle must show no lost cycle in forwarding mode and exactly one in stall mode. A dependency two slots apart is run beside these cases, to show that a write completed at the clock edge is seen without any extra action.

// File: rtl/p3a_pkg.sv
package p3a_pkg;
  localparam int unsigned IW = 32;
  localparam logic [1:0] CLS_ALU = 2'b10;
  localparam logic [5:0] OPC_ADD = 6'b000000;

  typedef struct packed {
    logic       is_add;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
  } dec_t;

  function automatic dec_t decode_word(input logic [IW-1:0] w);
    dec_t d;
    d.rd     = w[29:25];
    d.rs1    = w[18:14];
    d.rs2    = w[4:0];
    d.is_add = (w[31:30] == CLS_ALU) && (w[24:19] == OPC_ADD) && !w[13];
    return d;
  endfunction
endpackage

// File: rtl/p3a_imem.sv
module p3a_imem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned IW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/p3a_regfile.sv
module p3a_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 32,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [DW-1:0] wr_val,
  input  logic          pre_en,
  input  logic [RW-1:0] pre_idx,
  input  logic [DW-1:0] pre_val,
  input  logic [RW-1:0] rd_idx_a,
  input  logic [RW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_val_a,
  output logic [DW-1:0] rd_val_b
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(NREG); i++) begin
      if (!rst_n)                             regs[i] <= '0;
      else if (wr_en && wr_idx == RW'(i))     regs[i] <= wr_val;
      else if (pre_en && pre_idx == RW'(i))   regs[i] <= pre_val;
    end
  end

  assign rd_val_a = regs[rd_idx_a];
  assign rd_val_b = regs[rd_idx_b];
endmodule

// File: rtl/p3a_hazard.sv
module p3a_hazard #(
  parameter bit          FWD = 1'b1,
  parameter int unsigned RW  = 5
) (
  input  logic          id_add,
  input  logic [RW-1:0] rs_a,
  input  logic [RW-1:0] rs_b,
  input  logic          ex_live,
  input  logic [RW-1:0] ex_dst,
  output logic          raw_a,
  output logic          raw_b,
  output logic          fwd_a,
  output logic          fwd_b,
  output logic          stall
);
  assign raw_a = id_add && ex_live && (rs_a == ex_dst);
  assign raw_b = id_add && ex_live && (rs_b == ex_dst);

  generate
    if (FWD) begin : g_forward
      assign fwd_a = raw_a;
      assign fwd_b = raw_b;
      assign stall = 1'b0;
    end else begin : g_bubble
      assign fwd_a = 1'b0;
      assign fwd_b = 1'b0;
      assign stall = raw_a | raw_b;
    end
  endgenerate
endmodule

// File: rtl/pipe3_add_core.sv
module pipe3_add_core #(
  parameter int unsigned NREG       = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned IMEM_DEPTH = 64,
  parameter bit          FWD_MODE   = 1'b1,
  localparam int unsigned RW        = $clog2(NREG),
  localparam int unsigned IAW       = $clog2(IMEM_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    imem_we,
  input  logic [IAW-1:0]          imem_waddr,
  input  logic [p3a_pkg::IW-1:0]  imem_wdata,
  input  logic                    rf_pre_we,
  input  logic [RW-1:0]           rf_pre_idx,
  input  logic [DW-1:0]           rf_pre_data,
  output logic [31:0]             pc_o,
  output logic                    wb_valid,
  output logic [RW-1:0]           wb_rd,
  output logic [DW-1:0]           wb_data
);
  function automatic logic [DW-1:0] add_wrap(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  // stage 1: fetch
  logic [31:0]             pc_q;
  logic [p3a_pkg::IW-1:0]  if_word;
  logic                    id_valid;
  logic [p3a_pkg::IW-1:0]  id_word;

  // stage 2: decode / operand select
  p3a_pkg::dec_t           dec;
  logic                    id_add;
  logic [DW-1:0]           rf_a, rf_b, op_a, op_b;
  logic                    raw_a, raw_b, raw_any, fwd_a, fwd_b, fwd_any, stall;

  // stage 3: execute / write-back
  logic                    ex_valid;
  logic [RW-1:0]           ex_rd;
  logic [DW-1:0]           ex_a, ex_b, ex_sum;

  p3a_imem #(.DEPTH(IMEM_DEPTH), .IW(p3a_pkg::IW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr(pc_q[IAW+1:2]), .rdata(if_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      id_valid <= 1'b0;
      id_word  <= '0;
    end else if (!stall) begin
      pc_q     <= pc_q + 32'd4;
      id_valid <= 1'b1;
      id_word  <= if_word;
    end
  end

  assign dec    = p3a_pkg::decode_word(id_word);
  assign id_add = id_valid && dec.is_add;

  p3a_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ex_valid), .wr_idx(ex_rd), .wr_val(ex_sum),
    .pre_en(rf_pre_we), .pre_idx(rf_pre_idx), .pre_val(rf_pre_data),
    .rd_idx_a(dec.rs1[RW-1:0]), .rd_idx_b(dec.rs2[RW-1:0]),
    .rd_val_a(rf_a), .rd_val_b(rf_b)
  );

  p3a_hazard #(.FWD(FWD_MODE), .RW(RW)) u_haz (
    .id_add(id_add), .rs_a(dec.rs1[RW-1:0]), .rs_b(dec.rs2[RW-1:0]),
    .ex_live(ex_valid), .ex_dst(ex_rd),
    .raw_a(raw_a), .raw_b(raw_b), .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall)
  );

  assign raw_any = raw_a | raw_b;
  assign fwd_any = fwd_a | fwd_b;
  assign op_a    = fwd_a ? ex_sum : rf_a;
  assign op_b    = fwd_b ? ex_sum : rf_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_rd    <= '0;
      ex_a     <= '0;
      ex_b     <= '0;
    end else begin
      ex_valid <= id_add && !stall;
      ex_rd    <= dec.rd[RW-1:0];
      ex_a     <= op_a;
      ex_b     <= op_b;
    end
  end

  assign ex_sum   = add_wrap(ex_a, ex_b);
  assign pc_o     = pc_q;
  assign wb_valid = ex_valid;
  assign wb_rd    = ex_rd;
  assign wb_data  = ex_sum;
endmodule

// File: rtl/p3a_chk.sv
module p3a_chk #(
  parameter bit          FWD = 1'b1,
  parameter int unsigned DW  = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          raw_any,
  input logic          fwd_any,
  input logic [31:0]   pc,
  input logic          wb_valid,
  input logic [DW-1:0] wb_data
);
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) !stall |=> pc == $past(pc) + 32'd4); // R7
  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n) stall |=> $stable(pc)); // R5
  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !wb_valid); // R8
  AST_RAW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) (raw_any && !fwd_any) |=> !raw_any); // R5
  AST_FWD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n) raw_any |-> (fwd_any != stall)); // R4
  AST_WB_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) wb_valid |-> !$isunknown(wb_data)); // R1
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (pc == 32'd0 && !wb_valid)); // R9
endmodule

bind pipe3_add_core p3a_chk #(.FWD(FWD_MODE), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .raw_any(raw_any), .fwd_any(fwd_any),
  .pc(pc_q), .wb_valid(wb_valid), .wb_data(wb_data)
);

// File: tb/sim_pipe3_add_core.sv
`timescale 1ns/1ps
module sim_pipe3_add_core;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic        pre_we = 1'b0;
  logic [4:0]  pre_idx = '0;
  logic [31:0] pre_data = '0;

  logic [31:0] pc_w   [2];
  logic        wbv    [2];
  logic [4:0]  wbr    [2];
  logic [31:0] wbd    [2];

  pipe3_add_core #(.FWD_MODE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .rf_pre_we(pre_we), .rf_pre_idx(pre_idx), .rf_pre_data(pre_data),
    .pc_o(pc_w[0]), .wb_valid(wbv[0]), .wb_rd(wbr[0]), .wb_data(wbd[0]));

  pipe3_add_core #(.FWD_MODE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .rf_pre_we(pre_we), .rf_pre_idx(pre_idx), .rf_pre_data(pre_data),
    .pc_o(pc_w[1]), .wb_valid(wbv[1]), .wb_rd(wbr[1]), .wb_data(wbd[1]));

  int tests = 0;
  int failed = 0;
  int cyc = 0;
  logic [31:0] prog [64];

  int          lcyc [2][16];
  int          lrd  [2][16];
  logic [31:0] ldat [2][16];
  int          lnum [2];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 2; d++) begin
        if (wbv[d] === 1'b1 && lnum[d] < 16) begin
          lcyc[d][lnum[d]] = cyc;
          lrd[d][lnum[d]]  = int'(wbr[d]);
          ldat[d][lnum[d]] = wbd[d];
          lnum[d] = lnum[d] + 1;
        end
      end
    end
  end

  function automatic logic [31:0] enc_add(input int rd, input int rs1, input int rs2);
    return {2'b10, 5'(rd), 6'b000000, 5'(rs1), 1'b0, 8'h00, 5'(rs2)};
  endfunction

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_wb(input int d, input int k, input int c, input int rd,
                          input logic [31:0] v, input string tag);
    string t;
    t = $sformatf("%s dut%0d wb#%0d", tag, d, k);
    if (k >= lnum[d]) begin
      tests++; failed++;
      $display("FAIL %s missing actual=%0d events expected>%0d", t, lnum[d], k);
    end else begin
      check_eq({t, " cycle"}, 32'(lcyc[d][k]), 32'(c));
      check_eq({t, " rd"},    32'(lrd[d][k]),  32'(rd));
      check_eq({t, " data"},  ldat[d][k],      v);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
  endtask

  // reset, load store, release, preload r2/r3/r6
  task automatic start_run(input logic [31:0] v2);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    lnum[0] = 0; lnum[1] = 0;
    for (int d = 0; d < 2; d++) begin
      check_eq($sformatf("R9 reset pc dut%0d", d), pc_w[d], 32'h0);
      check_eq($sformatf("R9 reset wb_valid dut%0d", d), 32'(wbv[d]), 32'h0);
    end
    rst_n = 1'b1;
    pre_we = 1'b1; pre_idx = 5'd2; pre_data = v2;
    @(negedge clk);
    pre_idx = 5'd3; pre_data = 32'd3;
    @(negedge clk);
    pre_idx = 5'd6; pre_data = 32'd6;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic t_example();
    clear_prog();
    prog[4] = enc_add(1, 2, 3);
    prog[5] = enc_add(4, 1, 3);
    prog[6] = enc_add(5, 6, 3);
    start_run(32'd2);
    wait_to(3);
    check_eq("R7 pc at cycle 3", pc_w[0], 32'd12);
    wait_to(7);
    check_eq("R7 R4 pc fwd cycle 7", pc_w[0], 32'd28);
    check_eq("R7 R5 pc held stall cycle 7", pc_w[1], 32'd24);
    check_eq("R8 bubble no pulse", 32'(wbv[1]), 32'h0);
    wait_to(11);
    check_wb(0, 0, 6, 1, 32'd5, "R6 R3");
    check_wb(0, 1, 7, 4, 32'd8, "R6 R4");
    check_wb(0, 2, 8, 5, 32'd9, "R6");
    check_wb(1, 0, 6, 1, 32'd5, "R6");
    check_wb(1, 1, 8, 4, 32'd8, "R6 R5");
    check_wb(1, 2, 9, 5, 32'd9, "R6 R5");
    check_eq("R8 fwd count", 32'(lnum[0]), 32'd3);
    check_eq("R8 stall count", 32'(lnum[1]), 32'd3);
  endtask

  task automatic t_wrap_throughput();
    clear_prog();
    prog[4] = enc_add(7, 2, 3);
    prog[5] = enc_add(8, 6, 6);
    prog[6] = enc_add(9, 3, 3);
    start_run(32'hFFFF_FFFF);
    wait_to(10);
    for (int d = 0; d < 2; d++) begin
      check_wb(d, 0, 6, 7, 32'd2, "R1 wrap");
      check_wb(d, 1, 7, 8, 32'd12, "R3");
      check_wb(d, 2, 8, 9, 32'd6, "R3");
    end
  endtask

  task automatic t_noop_words();
    clear_prog();
    prog[4] = {2'b00, 5'd1, 6'b000000, 5'd2, 1'b0, 8'h00, 5'd3};
    prog[5] = {2'b10, 5'd1, 6'b000001, 5'd2, 1'b0, 8'h00, 5'd3};
    prog[6] = {2'b10, 5'd1, 6'b000000, 5'd2, 1'b1, 8'h00, 5'd3};
    prog[7] = enc_add(10, 11, 12);
    prog[8] = enc_add(4, 1, 3);
    start_run(32'd2);
    wait_to(12);
    for (int d = 0; d < 2; d++) begin
      check_wb(d, 0, 9, 10, 32'd0, "R9 regs zero");
      check_wb(d, 1, 10, 4, 32'd3, "R2 r1 untouched");
      check_eq($sformatf("R2 R8 pulse count dut%0d", d), 32'(lnum[d]), 32'd2);
    end
  endtask

  task automatic t_chain();
    clear_prog();
    prog[4] = enc_add(1, 2, 3);
    prog[5] = enc_add(4, 6, 6);
    prog[6] = enc_add(5, 1, 3);
    prog[7] = enc_add(5, 5, 5);
    prog[8] = enc_add(5, 1, 5);
    start_run(32'd2);
    wait_to(14);
    check_wb(0, 2, 8, 5, 32'd8, "R10 fwd");
    check_wb(0, 3, 9, 5, 32'd16, "R4 chain");
    check_wb(0, 4, 10, 5, 32'd21, "R4 rs2");
    check_wb(1, 1, 7, 4, 32'd12, "R3");
    check_wb(1, 2, 8, 5, 32'd8, "R10 stall");
    check_wb(1, 3, 10, 5, 32'd16, "R5 chain");
    check_wb(1, 4, 12, 5, 32'd21, "R5 rs2");
  endtask

  task automatic t_store_wrap();
    clear_prog();
    prog[4]  = enc_add(1, 2, 3);
    prog[63] = enc_add(11, 2, 2);
    start_run(32'd2);
    wait_to(72);
    for (int d = 0; d < 2; d++) begin
      check_wb(d, 0, 6, 1, 32'd5, "R11");
      check_wb(d, 1, 65, 11, 32'd4, "R11 last word");
      check_wb(d, 2, 70, 1, 32'd5, "R11 wrap refetch");
    end
  endtask

  task automatic t_preload_priority();
    clear_prog();
    prog[4] = enc_add(9, 2, 3);
    prog[5] = enc_add(12, 9, 9);
    start_run(32'd2);
    wait_to(5);
    // word4 writes r9 at edge 7; a load to r9 on that same edge must lose
    @(negedge clk);
    pre_we = 1'b1; pre_idx = 5'd9; pre_data = 32'h55;
    @(negedge clk);
    pre_we = 1'b0;
    wait_to(10);
    check_wb(1, 1, 8, 12, 32'd10, "R12 pipeline wins");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; failed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    lnum[0] = 0; lnum[1] = 0;
    repeat (2) @(negedge clk);
    t_example();
    t_wrap_throughput();
    t_noop_words();
    t_chain();
    t_store_wrap();
    t_preload_priority();
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule